// File: doc/BRIEF.md
# Bit-plane pixel sorter with Gray decode

This block takes the single-bit stream that one deserialized pixel link delivers from a column-parallel ADC array and turns it back into pixels. The array sends its samples one bit plane at a time. For one row of ADCs, the least significant bit of every column arrives first, then the next plane for every column, and so on up to the top plane. The block writes each incoming bit into a two-bank row buffer, which transposes the planes into per-column words. When a row is complete, it reads the words back in column order. It converts each Gray-coded word to binary and presents one pixel per clock with its column index, row index, an end-of-row flag and an end-of-block flag.

A block is a stripe of ADC rows that are quantized together. A sync pulse marks the first bit of each block. The sample width is sampled at that sync, and it is either the narrow (9-bit) or the wide (10-bit) setting. While one bank is being read out, the other bank fills with the next row, so a continuous input stream never has to stall.

Top module: `bitplane_sorter`

## Requirements
- R1: After reset, and until a row has been fully received, pix_valid_o, pix_eol_o and pix_last_o are low.
- R2: Input bits taken before the first sync_i (qualified by bit_valid_i) are discarded and produce no pixels.
- R3: Within a row, input bit number p*NUM_COLS + c (counted from 0) is bit p of column c's sample. Plane 0 is the LSB.
- R4: Each output value is the binary decode of the received Gray word: b[MSB]=g[MSB] and b[i]=b[i+1] XOR g[i].
- R5: wide_i is sampled together with a qualified sync_i. When it is 1, each row has 10 planes. When it is 0, each row has 9 planes and output bit 9 is always 0, whatever the buffer held from earlier wide rows.
- R6: A complete row produces NUM_COLS pixels on consecutive cycles, with pix_col_o running 0 to NUM_COLS-1 and pix_row_o steady. Rows are numbered 0 to NUM_ROWS-1 from the sync.
- R7: pix_eol_o is high only on the column NUM_COLS-1 pixel. pix_last_o is high only on the pixel at column NUM_COLS-1 of row NUM_ROWS-1.
- R8: Once the last bit of row NUM_ROWS-1 has been taken, further bits are discarded until the next qualified sync_i.
- R9: A qualified sync_i in the middle of a block restarts reception at row 0, column 0, plane 0. The unfinished row produces no pixels.
- R10: An unbroken input stream across rows and blocks is accepted at one bit per clock with no loss, because readout of a row overlaps reception of the next.
- R11: Cycles with bit_valid_i low have no effect, even when sync_i is high during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit |
| bit_valid_i | input | 1 | bit_i holds a bit this cycle |
| sync_i | input | 1 | This valid bit is the first of a block |
| wide_i | input | 1 | Sample width at sync: 1 = 10 bits, 0 = 9 bits |
| pix_valid_o | output | 1 | Pixel strobe |
| pix_data_o | output | WIDE_BITS | Binary pixel value |
| pix_col_o | output | clog2(NUM_COLS) | Column index of the pixel |
| pix_row_o | output | clog2(NUM_ROWS) | Row index of the pixel |
| pix_eol_o | output | 1 | Last pixel of a row |
| pix_last_o | output | 1 | Last pixel of the block |

## Verification
Each column gets a distinct value, and three columns are pinned to all-ones, zero and top-bit-only. A wrong plane-to-column mapping, an off-by-one plane, or a decode that skips the XOR chain therefore shows up at a known column. Blocks are run in both widths, and a narrow block follows a wide one so that a stale bit 9 in the buffer would be caught. The stream is sent both unbroken and with idle gaps, and sync_i is held high during some of the gaps, which separates correct bit qualification from a counter that advances on every cycle. Noise before the first sync, surplus bits after a block, and a block abandoned after one and a half rows test the discard and restart rules.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int unsigned GRAY_W = 16;

  // prefix-XOR from the MSB down; zero-extended inputs decode unchanged
  function automatic logic [GRAY_W-1:0] gray_to_bin(input logic [GRAY_W-1:0] g);
    logic [GRAY_W-1:0] b;
    b[GRAY_W-1] = g[GRAY_W-1];
    for (int i = GRAY_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/bps_capture.sv
module bps_capture #(
  parameter int unsigned NUM_COLS    = 40,
  parameter int unsigned NUM_ROWS    = 20,
  parameter int unsigned NARROW_BITS = 9,
  parameter int unsigned WIDE_BITS   = 10,
  localparam int unsigned COL_W = $clog2(NUM_COLS),
  localparam int unsigned ROW_W = $clog2(NUM_ROWS),
  localparam int unsigned PLN_W = $clog2(WIDE_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_valid_i,
  input  logic             sync_i,
  input  logic             wide_i,
  output logic             wr_en_o,
  output logic             wr_bank_o,
  output logic [COL_W-1:0] wr_col_o,
  output logic [PLN_W-1:0] wr_plane_o,
  output logic             wr_bit_o,
  output logic             done_o,
  output logic             done_bank_o,
  output logic [ROW_W-1:0] done_row_o,
  output logic             done_last_o,
  output logic             done_wide_o
);
  localparam logic [COL_W-1:0] COL_MAX = COL_W'(NUM_COLS - 1);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(NUM_ROWS - 1);
  localparam logic [PLN_W-1:0] PLN_NAR = PLN_W'(NARROW_BITS - 1);
  localparam logic [PLN_W-1:0] PLN_WID = PLN_W'(WIDE_BITS - 1);

  logic             armed_q, wide_q, bank_q;
  logic [COL_W-1:0] col_q, cur_col;
  logic [PLN_W-1:0] plane_q, cur_plane, top_plane;
  logic [ROW_W-1:0] row_q, cur_row;
  logic             take, cur_wide, col_end, plane_end, row_end, blk_end;

  always_comb begin
    take      = bit_valid_i && (sync_i || armed_q);
    cur_col   = sync_i ? '0 : col_q;
    cur_plane = sync_i ? '0 : plane_q;
    cur_row   = sync_i ? '0 : row_q;
    cur_wide  = sync_i ? wide_i : wide_q;
    top_plane = cur_wide ? PLN_WID : PLN_NAR;
    col_end   = (cur_col == COL_MAX);
    plane_end = (cur_plane == top_plane);
    row_end   = col_end && plane_end;
    blk_end   = row_end && (cur_row == ROW_MAX);
  end

  assign wr_en_o    = take;
  assign wr_bank_o  = bank_q;
  assign wr_col_o   = cur_col;
  assign wr_plane_o = cur_plane;
  assign wr_bit_o   = bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q     <= 1'b0;
      wide_q      <= 1'b0;
      bank_q      <= 1'b0;
      col_q       <= '0;
      plane_q     <= '0;
      row_q       <= '0;
      done_o      <= 1'b0;
      done_bank_o <= 1'b0;
      done_row_o  <= '0;
      done_last_o <= 1'b0;
      done_wide_o <= 1'b0;
    end else begin
      done_o <= take && row_end;
      if (take) begin
        armed_q <= !blk_end;
        wide_q  <= cur_wide;
        col_q   <= col_end ? '0 : cur_col + 1'b1;
        if (col_end) plane_q <= plane_end ? '0 : cur_plane + 1'b1;
        else         plane_q <= cur_plane;
        if (row_end) row_q <= blk_end ? '0 : cur_row + 1'b1;
        else         row_q <= cur_row;
        if (row_end) begin
          bank_q      <= ~bank_q;
          done_bank_o <= bank_q;
          done_row_o  <= cur_row;
          done_last_o <= blk_end;
          done_wide_o <= cur_wide;
        end
      end
    end
  end
endmodule

// File: rtl/bps_buffer.sv
module bps_buffer #(
  parameter int unsigned NUM_COLS  = 40,
  parameter int unsigned WIDE_BITS = 10,
  localparam int unsigned COL_W = $clog2(NUM_COLS),
  localparam int unsigned PLN_W = $clog2(WIDE_BITS)
) (
  input  logic                 clk_i,
  input  logic                 wr_en_i,
  input  logic                 wr_bank_i,
  input  logic [COL_W-1:0]     wr_col_i,
  input  logic [PLN_W-1:0]     wr_plane_i,
  input  logic                 wr_bit_i,
  input  logic                 rd_bank_i,
  input  logic [COL_W-1:0]     rd_col_i,
  output logic [WIDE_BITS-1:0] rd_word_o
);
  logic [WIDE_BITS-1:0] words [2][NUM_COLS];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_bank_i == b[0]))
        words[b][wr_col_i][wr_plane_i] <= wr_bit_i;
    end
  end

  assign rd_word_o = words[rd_bank_i][rd_col_i];
endmodule

// File: rtl/bps_emitter.sv
module bps_emitter
  import bps_pkg::*;
#(
  parameter int unsigned NUM_COLS    = 40,
  parameter int unsigned NUM_ROWS    = 20,
  parameter int unsigned NARROW_BITS = 9,
  parameter int unsigned WIDE_BITS   = 10,
  localparam int unsigned COL_W = $clog2(NUM_COLS),
  localparam int unsigned ROW_W = $clog2(NUM_ROWS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 start_bank_i,
  input  logic [ROW_W-1:0]     start_row_i,
  input  logic                 start_last_i,
  input  logic                 start_wide_i,
  input  logic [WIDE_BITS-1:0] rd_word_i,
  output logic                 rd_bank_o,
  output logic [COL_W-1:0]     rd_col_o,
  output logic                 pix_valid_o,
  output logic [WIDE_BITS-1:0] pix_data_o,
  output logic [COL_W-1:0]     pix_col_o,
  output logic [ROW_W-1:0]     pix_row_o,
  output logic                 pix_eol_o,
  output logic                 pix_last_o
);
  localparam logic [COL_W-1:0]     COL_MAX  = COL_W'(NUM_COLS - 1);
  localparam logic [WIDE_BITS-1:0] NAR_MASK = WIDE_BITS'((1 << NARROW_BITS) - 1);

  logic             active_q, bank_q, last_q, wide_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [WIDE_BITS-1:0] masked;
  logic [GRAY_W-1:0]    decoded;
  logic                 at_end;

  assign rd_bank_o = bank_q;
  assign rd_col_o  = col_q;
  assign at_end    = (col_q == COL_MAX);

  always_comb begin
    masked  = rd_word_i & (wide_q ? '1 : NAR_MASK);
    decoded = gray_to_bin(GRAY_W'(masked));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      bank_q   <= 1'b0;
      last_q   <= 1'b0;
      wide_q   <= 1'b0;
      col_q    <= '0;
      row_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      bank_q   <= start_bank_i;
      last_q   <= start_last_i;
      wide_q   <= start_wide_i;
      row_q    <= start_row_i;
      col_q    <= '0;
    end else if (active_q) begin
      col_q <= at_end ? '0 : col_q + 1'b1;
      if (at_end) active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      pix_data_o  <= '0;
      pix_col_o   <= '0;
      pix_row_o   <= '0;
      pix_eol_o   <= 1'b0;
      pix_last_o  <= 1'b0;
    end else begin
      pix_valid_o <= active_q;
      pix_eol_o   <= active_q && at_end;
      pix_last_o  <= active_q && at_end && last_q;
      if (active_q) begin
        pix_data_o <= decoded[WIDE_BITS-1:0];
        pix_col_o  <= col_q;
        pix_row_o  <= row_q;
      end
    end
  end
endmodule

// File: rtl/bitplane_sorter.sv
module bitplane_sorter #(
  parameter int unsigned NUM_COLS    = 40,
  parameter int unsigned NUM_ROWS    = 20,
  parameter int unsigned NARROW_BITS = 9,
  parameter int unsigned WIDE_BITS   = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bit_i,
  input  logic                        bit_valid_i,
  input  logic                        sync_i,
  input  logic                        wide_i,
  output logic                        pix_valid_o,
  output logic [WIDE_BITS-1:0]        pix_data_o,
  output logic [$clog2(NUM_COLS)-1:0] pix_col_o,
  output logic [$clog2(NUM_ROWS)-1:0] pix_row_o,
  output logic                        pix_eol_o,
  output logic                        pix_last_o
);
  localparam int unsigned COL_W = $clog2(NUM_COLS);
  localparam int unsigned ROW_W = $clog2(NUM_ROWS);
  localparam int unsigned PLN_W = $clog2(WIDE_BITS);

  logic             wr_en, wr_bank, wr_bit;
  logic [COL_W-1:0] wr_col, rd_col;
  logic [PLN_W-1:0] wr_plane;
  logic             done, done_bank, done_last, done_wide, rd_bank;
  logic [ROW_W-1:0] done_row;
  logic [WIDE_BITS-1:0] rd_word;

  bps_capture #(
    .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS),
    .NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)
  ) u_capture (
    .clk_i, .rst_ni, .bit_i, .bit_valid_i, .sync_i, .wide_i,
    .wr_en_o(wr_en), .wr_bank_o(wr_bank), .wr_col_o(wr_col),
    .wr_plane_o(wr_plane), .wr_bit_o(wr_bit),
    .done_o(done), .done_bank_o(done_bank), .done_row_o(done_row),
    .done_last_o(done_last), .done_wide_o(done_wide)
  );

  bps_buffer #(.NUM_COLS(NUM_COLS), .WIDE_BITS(WIDE_BITS)) u_buffer (
    .clk_i,
    .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_col_i(wr_col),
    .wr_plane_i(wr_plane), .wr_bit_i(wr_bit),
    .rd_bank_i(rd_bank), .rd_col_i(rd_col), .rd_word_o(rd_word)
  );

  bps_emitter #(
    .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS),
    .NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)
  ) u_emitter (
    .clk_i, .rst_ni,
    .start_i(done), .start_bank_i(done_bank), .start_row_i(done_row),
    .start_last_i(done_last), .start_wide_i(done_wide),
    .rd_word_i(rd_word), .rd_bank_o(rd_bank), .rd_col_o(rd_col),
    .pix_valid_o, .pix_data_o, .pix_col_o, .pix_row_o, .pix_eol_o, .pix_last_o
  );
endmodule

// File: rtl/bps_checker.sv
module bps_checker #(
  parameter int unsigned NUM_COLS = 40,
  parameter int unsigned NUM_ROWS = 20,
  localparam int unsigned COL_W = $clog2(NUM_COLS),
  localparam int unsigned ROW_W = $clog2(NUM_ROWS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_valid_i,
  input logic             sync_i,
  input logic             pix_valid_o,
  input logic [COL_W-1:0] pix_col_o,
  input logic [ROW_W-1:0] pix_row_o,
  input logic             pix_eol_o,
  input logic             pix_last_o
);
  logic seen_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_sync_q <= 1'b0;
    else if (bit_valid_i && sync_i) seen_sync_q <= 1'b1;
  end

  p_quiet_before_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_sync_q |-> !pix_valid_o);

  p_index_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (pix_col_o < COL_W'(NUM_COLS)) && (pix_row_o < ROW_W'(NUM_ROWS)));

  p_col_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_eol_o |=> pix_valid_o && (pix_col_o == $past(pix_col_o) + 1'b1)
                                  && $stable(pix_row_o));

  p_eol_col_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_eol_o |-> pix_valid_o && (pix_col_o == COL_W'(NUM_COLS - 1)));

  p_last_pos_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_last_o |-> pix_eol_o && (pix_row_o == ROW_W'(NUM_ROWS - 1)));
endmodule

bind bitplane_sorter bps_checker #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_bps_checker (
  .clk_i, .rst_ni, .bit_valid_i, .sync_i,
  .pix_valid_o, .pix_col_o, .pix_row_o, .pix_eol_o, .pix_last_o
);

// File: tb/tb_bitplane_sorter.sv
module tb_bitplane_sorter;
  localparam int COLS = 40, ROWS = 20, NB = 9, WB = 10;

  typedef struct packed {
    logic          last;
    logic          eol;
    logic [4:0]    row;
    logic [5:0]    col;
    logic [WB-1:0] data;
  } pix_t;

  logic clk = 0, rst_n = 0;
  logic bit_in = 0, bit_vld = 0, sync = 0, wide = 0;
  logic          pv, peol, plast;
  logic [WB-1:0] pdata;
  logic [5:0]    pcol;
  logic [4:0]    prow;

  int total = 0, bad = 0;
  bit finished = 0;
  pix_t got[$], exp_q[$];

  always #4 clk = ~clk;

  bitplane_sorter #(.NUM_COLS(COLS), .NUM_ROWS(ROWS), .NARROW_BITS(NB), .WIDE_BITS(WB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .bit_valid_i(bit_vld),
    .sync_i(sync), .wide_i(wide),
    .pix_valid_o(pv), .pix_data_o(pdata), .pix_col_o(pcol), .pix_row_o(prow),
    .pix_eol_o(peol), .pix_last_o(plast)
  );

  always @(negedge clk) if (rst_n && pv) got.push_back('{plast, peol, prow, pcol, pdata});

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int pat(int seed, int r, int c, int nb);
    int v = seed * 97 + r * 31 + c * 53 + r * c * 7;
    if (c == 0) v = -1;
    if (c == 1) v = 0;
    if (c == 2) v = 1 << (nb - 1);
    return v & ((1 << nb) - 1);
  endfunction

  task automatic put_bit(logic b, logic s);
    @(negedge clk);
    bit_in = b; sync = s; bit_vld = 1;
  endtask

  task automatic idle(int n, logic s);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld = 0; sync = s; bit_in = i[0];
    end
    @(negedge clk);
    sync = 0;
  endtask

  // full rows with sync on the first bit, then extra_bits of an unfinished row
  task automatic send_rows(int seed, bit w, int nrows, bit gap, int extra_bits);
    int nb = w ? WB : NB;
    int idx = 0;
    wide = w;
    for (int r = 0; r <= nrows; r++) begin
      for (int p = 0; p < nb; p++) begin
        for (int c = 0; c < COLS; c++) begin
          int v = pat(seed, r, c, nb);
          int g = v ^ (v >> 1);
          if (r == nrows && (p * COLS + c) >= extra_bits) continue;
          if (gap && (idx % 3) == 2) idle(1, 1'b1);
          put_bit(g[p], idx == 0);
          idx++;
        end
      end
      if (r < nrows)
        for (int c = 0; c < COLS; c++)
          exp_q.push_back('{(r == ROWS - 1) && (c == COLS - 1), c == COLS - 1,
                            5'(r), 6'(c), WB'(pat(seed, r, c, nb))});
    end
    @(negedge clk);
    bit_vld = 0; sync = 0;
  endtask

  task automatic compare(string req);
    idle(80, 1'b0);
    check(got.size() == exp_q.size(), req, "pixel count", got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      check(got[i] == exp_q[i], req, $sformatf("pixel %0d {last,eol,row,col,data}", i),
            got[i], exp_q[i]);
    got.delete(); exp_q.delete();
  endtask

  task automatic t_reset();
    check(pv == 0 && peol == 0 && plast == 0, "R1", "outputs after reset", {pv, peol, plast}, 0);
    idle(20, 1'b0);
    check(got.size() == 0, "R1", "pixels while idle", got.size(), 0);
  endtask

  task automatic t_noise_then_block();
    for (int i = 0; i < 500; i++) put_bit(((i * 7) % 3) == 0, 1'b0);
    idle(60, 1'b0);
    check(got.size() == 0, "R2", "pixels from pre-sync bits", got.size(), 0);
    send_rows(1, 1'b0, ROWS, 1'b0, 0);
    compare("R2 R3 R4 R6 R7 R10 narrow block");
  endtask

  task automatic t_wide_back_to_back();
    send_rows(5, 1'b1, ROWS, 1'b0, 0);
    send_rows(9, 1'b1, ROWS, 1'b0, 0);
    compare("R5 R10 wide back-to-back");
  endtask

  task automatic t_narrow_gaps();
    send_rows(3, 1'b0, ROWS, 1'b1, 0);
    idle(80, 1'b0);
    for (int i = 0; i < got.size(); i++)
      check(got[i].data[WB-1] == 1'b0, "R5", "narrow bit 9 after wide block", got[i].data, 0);
    compare("R11 R5 gapped narrow after wide");
  endtask

  task automatic t_surplus_bits();
    for (int i = 0; i < 2 * NB * COLS; i++) put_bit(i[1], 1'b0);
    idle(80, 1'b0);
    check(got.size() == 0, "R8", "pixels from bits after block end", got.size(), 0);
  endtask

  task automatic t_restart();
    send_rows(11, 1'b0, 1, 1'b0, NB * COLS / 2);
    send_rows(13, 1'b1, ROWS, 1'b0, 0);
    compare("R9 restart mid-block");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_noise_then_block();
    t_wide_back_to_back();
    t_narrow_gaps();
    t_surplus_bits();
    t_restart();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule